// File: doc/BRIEF.md
# Host-Clocked Serial Read Port with Data-Ready Flag

This block is the device side of a serial read port whose bit clock comes from the host. A host lowers an active-low frame strobe and then toggles the serial clock. The block returns one of three sources most significant bit first: the conversion result register, the control register or the calibration register. A data-ready flag, active low, shows that an unread conversion result is waiting. The flag is set when the converter side presents a new word. It is cleared once the reader has clocked the final bit of that word out.

The host clock and the frame strobe are asynchronous to the system clock. They are brought into the system domain through a two-flop synchroniser and then edge-detected. For this to work the host clock may run at no more than one quarter of the system clock rate. A frame may be interrupted by raising the strobe and later resumed. The bit position is kept across the pause. Reads of the control and calibration registers ignore the flag and leave it alone. A result read is refused when no word is ready. A conversion word that arrives while a result read is in progress is discarded.

Top module: `hostclk_serial_reader`

## Requirements
- R1: After reset the data-ready flag `drdy_n_o` is high (nothing ready) and `sdo_en_o` is low.
- R2: A one-cycle pulse on `word_load_i` while no result read is in progress stores `word_data_i` in the result register and drives `drdy_n_o` low. A later read returns the most recently stored word, even if earlier words were never read.
- R3: Once the synchronised frame strobe falls, `sdo_o` carries bit 23 of the selected word and `sdo_en_o` goes high. Each synchronised falling edge of `sclk_i` inside the frame moves one bit toward bit 0.
- R4: Control and calibration reads are always 24 bits. A result read is 16 bits (word bits 23 down to 8) when `short_word_i` is 1 at frame start, and 24 bits otherwise.
- R5: On the falling edge that follows the last bit of a result word, `drdy_n_o` goes high and `sdo_en_o` goes low in the same cycle. A result-read frame that starts while `drdy_n_o` is high transfers nothing, and `sdo_en_o` stays low.
- R6: Source select at frame start: `sel_i`=0 selects the control word. `sel_i`=1 with `cal_pick_i`=1 selects the calibration word. `sel_i`=1 with `cal_pick_i`=0 selects the result register.
- R7: If the strobe rises mid-word, `sdo_en_o` drops and the bit position is held. Clock edges while the strobe is high are ignored. When the strobe falls again, the same pending bit is presented and shifting continues from it. `drdy_n_o` stays low until the whole result word has gone out.
- R8: A `word_load_i` pulse during a result read is dropped. The flag does not re-arm, so `drdy_n_o` is high once that read ends.
- R9: Control and calibration reads work whatever the state of `drdy_n_o` and never change it. A word loaded during such a read is accepted normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sclk_i | input | 1 | Host serial clock, asynchronous |
| rfs_n_i | input | 1 | Active-low read frame strobe, asynchronous |
| sel_i | input | 1 | 0: control word, 1: result or calibration word |
| cal_pick_i | input | 1 | With `sel_i`=1, 1 picks calibration, 0 picks result |
| short_word_i | input | 1 | Result reads use 16 bits when 1 |
| word_load_i | input | 1 | One-cycle strobe presenting a new conversion word |
| word_data_i | input | 24 | New conversion word |
| ctrl_word_i | input | 24 | Control register contents |
| cal_word_i | input | 24 | Calibration register contents |
| sdo_o | output | 1 | Serial data, MSB first |
| sdo_en_o | output | 1 | Serial data output enable |
| drdy_n_o | output | 1 | Data-ready flag, active low |

## Verification
The bench pauses frames in the middle of a word and toggles the clock while paused. A design that lost or skipped its bit position there would present the wrong bit on resume, or would drop the flag early. It tries result reads with the flag inactive, where a design lacking the gate would enable the output. It injects loads during result reads and during control reads. Here a wrong design either re-arms the flag after a dropped word, or fails to arm it after an accepted one. It checks that 16-bit result words end after bit 8. A design that ignored the length would keep the flag low and the output enabled past that point.

// File: rtl/rdr_pkg.sv
package rdr_pkg;
  typedef enum logic [1:0] {
    SRC_CTRL = 2'd0,
    SRC_CAL  = 2'd1,
    SRC_OUT  = 2'd2
  } src_e;
endpackage

// File: rtl/rdr_sync.sv
// Multi-bit double-flop synchroniser for asynchronous host lines.
module rdr_sync #(
  parameter int               WIDTH   = 2,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] level_o
);
  logic [WIDTH-1:0] chain_q [STAGES];
  logic [WIDTH-1:0] chain_d [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_comb chain_d[s] = async_i;
      end else begin : g_next
        always_comb chain_d[s] = chain_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= RST_VAL;
        else        chain_q[s] <= chain_d[s];
      end
    end
  endgenerate

  assign level_o = chain_q[STAGES-1];
endmodule

// File: rtl/rdr_word_store.sv
// Result register and data-ready flag.
module rdr_word_store #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         out_busy_i,
  input  logic         out_start_i,
  input  logic         out_done_i,
  output logic [W-1:0] word_o,
  output logic         drdy_n_o
);
  logic [W-1:0] word_q, word_d;
  logic         drdy_n_q, drdy_n_d;
  logic         accept;

  always_comb begin
    accept   = load_i && !out_busy_i && !out_start_i;
    word_d   = word_q;
    drdy_n_d = drdy_n_q;
    if (accept) begin
      word_d   = data_i;
      drdy_n_d = 1'b0;
    end else if (out_done_i) begin
      drdy_n_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q   <= '0;
      drdy_n_q <= 1'b1;
    end else begin
      word_q   <= word_d;
      drdy_n_q <= drdy_n_d;
    end
  end

  assign word_o   = word_q;
  assign drdy_n_o = drdy_n_q;

  // R5: the flag only returns inactive after a completed result word
  a_r5_drdy_rise_at_end : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drdy_n_q) |-> $past(out_done_i));
  // R8: a load during a result read never alters the stored word
  a_r8_drop_keeps_word : assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && out_busy_i) |=> $stable(word_q));
endmodule

// File: rtl/rdr_shift_ctrl.sv
// Frame tracking, source capture and bit shifting.
module rdr_shift_ctrl
  import rdr_pkg::*;
#(
  parameter int W       = 24,
  parameter int SHORT_W = 16,
  localparam int CW     = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rfs_lvl_i,
  input  logic         sclk_lvl_i,
  input  logic         sel_i,
  input  logic         cal_pick_i,
  input  logic         short_i,
  input  logic [W-1:0] ctrl_i,
  input  logic [W-1:0] cal_i,
  input  logic [W-1:0] out_word_i,
  input  logic         drdy_n_i,
  output logic         sdo_o,
  output logic         sdo_en_o,
  output logic         out_busy_o,
  output logic         out_start_o,
  output logic         out_done_o
);
  logic          rfs_prev_q, sclk_prev_q;
  logic          busy_q, busy_d;
  src_e          src_q, src_d, want_src;
  logic [CW-1:0] len_q, len_d, cnt_q, cnt_d;
  logic [W-1:0]  sh_q, sh_d;
  logic          frame_low, frame_fall, sclk_fall;
  logic          start, adv, last;

  always_comb begin
    frame_low  = !rfs_lvl_i;
    frame_fall = !rfs_lvl_i && rfs_prev_q;
    sclk_fall  = !sclk_lvl_i && sclk_prev_q;
    if (!sel_i)          want_src = SRC_CTRL;
    else if (cal_pick_i) want_src = SRC_CAL;
    else                 want_src = SRC_OUT;
    start = frame_fall && !busy_q && !(want_src == SRC_OUT && drdy_n_i);
    adv   = busy_q && frame_low && sclk_fall;
    last  = adv && (cnt_q == len_q - CW'(1));

    busy_d = busy_q;
    src_d  = src_q;
    len_d  = len_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    if (start) begin
      busy_d = 1'b1;
      src_d  = want_src;
      cnt_d  = '0;
      len_d  = (want_src == SRC_OUT && short_i) ? CW'(SHORT_W) : CW'(W);
      case (want_src)
        SRC_OUT: sh_d = out_word_i;
        SRC_CAL: sh_d = cal_i;
        default: sh_d = ctrl_i;
      endcase
    end else if (adv) begin
      if (last) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + CW'(1);
        sh_d  = {sh_q[W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rfs_prev_q  <= 1'b1;
      sclk_prev_q <= 1'b0;
      busy_q      <= 1'b0;
      src_q       <= SRC_CTRL;
      len_q       <= CW'(W);
      cnt_q       <= '0;
      sh_q        <= '0;
    end else begin
      rfs_prev_q  <= rfs_lvl_i;
      sclk_prev_q <= sclk_lvl_i;
      busy_q      <= busy_d;
      src_q       <= src_d;
      len_q       <= len_d;
      cnt_q       <= cnt_d;
      sh_q        <= sh_d;
    end
  end

  assign sdo_o       = sh_q[W-1];
  assign sdo_en_o    = busy_q && frame_low;
  assign out_busy_o  = busy_q && (src_q == SRC_OUT);
  assign out_start_o = start && (want_src == SRC_OUT);
  assign out_done_o  = last && (src_q == SRC_OUT);

  // R5: a result frame opened without a ready word never becomes active
  a_r5_blocked_frame : assert property (@(posedge clk) disable iff (!rst_n)
    (frame_fall && !busy_q && sel_i && !cal_pick_i && drdy_n_i) |=> !busy_q);
  // R7: the bit position is frozen while the strobe is high
  a_r7_hold_paused : assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !frame_low) |=> $stable(cnt_q));
  // R3: the position never reaches the word length while active
  a_r3_cnt_in_range : assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q < len_q));
  // R4: only the two legal lengths are ever in use
  a_r4_len_legal : assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (len_q == CW'(W) || len_q == CW'(SHORT_W)));
endmodule

// File: rtl/hostclk_serial_reader.sv
module hostclk_serial_reader #(
  parameter int W       = 24,
  parameter int SHORT_W = 16,
  parameter int STAGES  = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk_i,
  input  logic         rfs_n_i,
  input  logic         sel_i,
  input  logic         cal_pick_i,
  input  logic         short_word_i,
  input  logic         word_load_i,
  input  logic [W-1:0] word_data_i,
  input  logic [W-1:0] ctrl_word_i,
  input  logic [W-1:0] cal_word_i,
  output logic         sdo_o,
  output logic         sdo_en_o,
  output logic         drdy_n_o
);
  logic         rst_meta_q, rst_sync_n;
  logic [1:0]   host_lvl;
  logic [W-1:0] out_word;
  logic         out_busy, out_start, out_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  rdr_sync #(.WIDTH(2), .STAGES(STAGES), .RST_VAL(2'b10)) u_sync (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .async_i ({rfs_n_i, sclk_i}),
    .level_o (host_lvl)
  );

  rdr_word_store #(.W(W)) u_store (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .load_i      (word_load_i),
    .data_i      (word_data_i),
    .out_busy_i  (out_busy),
    .out_start_i (out_start),
    .out_done_i  (out_done),
    .word_o      (out_word),
    .drdy_n_o    (drdy_n_o)
  );

  rdr_shift_ctrl #(.W(W), .SHORT_W(SHORT_W)) u_shift (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .rfs_lvl_i   (host_lvl[1]),
    .sclk_lvl_i  (host_lvl[0]),
    .sel_i       (sel_i),
    .cal_pick_i  (cal_pick_i),
    .short_i     (short_word_i),
    .ctrl_i      (ctrl_word_i),
    .cal_i       (cal_word_i),
    .out_word_i  (out_word),
    .drdy_n_i    (drdy_n_o),
    .sdo_o       (sdo_o),
    .sdo_en_o    (sdo_en_o),
    .out_busy_o  (out_busy),
    .out_start_o (out_start),
    .out_done_o  (out_done)
  );

  // R5: output enable is already off when the flag returns inactive
  a_r5_en_off_with_drdy : assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(drdy_n_o) |-> !sdo_en_o);
  // R9: outside result reads and loads the flag does not move
  a_r9_drdy_untouched : assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!out_busy && !out_start && !word_load_i) |=> $stable(drdy_n_o));
endmodule

// File: tb/sim_hostclk_serial_reader.sv
module sim_hostclk_serial_reader;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sclk, rfs_n, sel, cal_pick, short_w, load;
  logic [23:0] ldata, m_ctrl, m_cal;
  logic        sdo, sdo_en, drdy_n;

  logic [23:0] m_out;
  bit          m_drdy_n, m_out_busy;
  int          checks = 0, fails = 0;

  always #(CLK_NS/2) clk = ~clk;

  hostclk_serial_reader u0 (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .rfs_n_i(rfs_n), .sel_i(sel),
    .cal_pick_i(cal_pick), .short_word_i(short_w), .word_load_i(load),
    .word_data_i(ldata), .ctrl_word_i(m_ctrl), .cal_word_i(m_cal),
    .sdo_o(sdo), .sdo_en_o(sdo_en), .drdy_n_o(drdy_n)
  );

  function automatic int exp_len(input bit s, input bit c, input bit sh);
    return (s && !c && sh) ? 16 : 24;
  endfunction

  function automatic logic [23:0] exp_word(input bit s, input bit c);
    if (!s) return m_ctrl;
    if (c)  return m_cal;
    return m_out;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_sclk(input int hold);
    sclk = 1'b1; tick(hold);
    sclk = 1'b0; tick(hold);
  endtask

  task automatic load_word(input logic [23:0] w);
    load = 1'b1; ldata = w;
    tick(1);
    load = 1'b0;
    if (!m_out_busy) begin
      m_out = w;
      m_drdy_n = 1'b0;
    end
  endtask

  task automatic do_read(input bit s, input bit c, input bit sh,
                         input int pause_at, input bit inject);
    logic [23:0] w;
    int          len;
    bit          is_out;
    sel = s; cal_pick = c; short_w = sh;
    is_out = s && !c;
    if (is_out && m_drdy_n) begin
      rfs_n = 1'b0; tick(6);
      chk("R5 blocked frame enable", sdo_en, 1'b0);
      repeat (3) pulse_sclk(4);
      tick(2);
      chk("R5 blocked frame stays off", sdo_en, 1'b0);
      chk("R5 blocked frame flag", drdy_n, 1'b1);
      rfs_n = 1'b1; tick(6);
      return;
    end
    w = exp_word(s, c);
    len = exp_len(s, c, sh);
    m_out_busy = is_out;
    rfs_n = 1'b0; tick(6);
    chk("R3/R6 msb at frame start", sdo, w[23]);
    chk("R3 enable at frame start", sdo_en, 1'b1);
    for (int i = 1; i <= len; i++) begin
      sclk = 1'b1; tick(4);
      sclk = 1'b0; tick(6);
      if (i < len) begin
        chk($sformatf("R3/R4/R6 bit %0d", i), sdo, w[23-i]);
        if (i == pause_at) begin
          rfs_n = 1'b1; tick(6);
          chk("R7 paused enable", sdo_en, 1'b0);
          repeat (2) pulse_sclk(4);
          rfs_n = 1'b0; tick(6);
          chk("R7 resumed bit", sdo, w[23-i]);
          chk("R7 resumed enable", sdo_en, 1'b1);
          if (is_out) chk("R7 flag held while paused", drdy_n, 1'b0);
        end
        if (inject && i == len/2) load_word($urandom);
      end
    end
    m_out_busy = 1'b0;
    if (is_out) m_drdy_n = 1'b1;
    chk("R5/R8/R9 flag after word", drdy_n, m_drdy_n);
    chk("R5 enable off after word", sdo_en, 1'b0);
    rfs_n = 1'b1; tick(6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; sclk = 1'b0; rfs_n = 1'b1; sel = 1'b0; cal_pick = 1'b0;
    short_w = 1'b0; load = 1'b0; ldata = '0;
    m_ctrl = 24'hC3A51E; m_cal = 24'h5AF00F; m_out = '0;
    m_drdy_n = 1'b1; m_out_busy = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    chk("R1 reset flag", drdy_n, 1'b1);
    chk("R1 reset enable", sdo_en, 1'b0);

    load_word(24'h123456);
    load_word(24'hA5C3E1);
    tick(1);
    chk("R2 flag after load", drdy_n, 1'b0);
    do_read(1, 0, 0, 0, 0);          // R2 newest word, 24 bits
    do_read(1, 0, 0, 0, 0);          // R5 blocked
    do_read(0, 0, 0, 5, 0);          // R9 control while not ready, R7 pause
    do_read(1, 1, 1, 0, 0);          // R4/R6 calibration ignores short
    load_word(24'hFEDCBA);
    do_read(1, 0, 1, 9, 0);          // R4 short result with R7 pause
    load_word(24'h0F0F0F);
    do_read(1, 0, 0, 0, 1);          // R8 load dropped mid read
    do_read(1, 0, 0, 0, 0);          // R8 still blocked afterwards
    do_read(0, 0, 0, 0, 1);          // R9 load accepted during control read
    do_read(1, 0, 0, 15, 0);         // R2 read of that word

    for (int r = 0; r < 40; r++) begin
      int nl;
      nl = $urandom_range(0, 2);
      for (int k = 0; k < nl; k++) begin
        load_word($urandom);
        tick($urandom_range(1, 3));
      end
      m_ctrl = $urandom;
      m_cal  = $urandom;
      do_read($urandom_range(0, 3) != 0, $urandom_range(0, 2) == 0,
              $urandom_range(0, 1) == 1, $urandom_range(0, 20),
              $urandom_range(0, 3) == 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule